// File: doc/BRIEF.md
# Multi-Outstanding DMA Request Tracker

The tracker sits between a DMA requester and a downstream line-oriented memory controller. Each request names a start byte address, a byte count and a direction. An accepted request takes a slot in a small fully associative table. It is then split into pieces no larger than one cache line. The first piece runs from the start offset to the end of its line. Each later piece starts at a line boundary. Only one piece per request is in flight at any time. The table tag of the request always holds the line address of that piece, so the downstream side answers with a line address and nothing else.

Many requests can be in flight together, and they may finish in any order. A request is refused in three cases. It is refused as full when every slot is taken. It is refused as aliased when any line it would touch is still pending for another request. It is told to retry when the single issue port is claimed in that cycle by the next piece of a running request. For reads, each response yields one data beat. The beat is aligned to byte zero and carries its destination byte position inside the transfer. When a request has all of its bytes accounted for, the tracker frees the slot and reports completion with the slot number.

Top module: `dmt_tracker`

## Requirements
- R1: After reset `busy`, `iss_valid`, `rd_valid`, `done_valid` and `rsp_err` are 0.
- R2: A request is accepted when `req_status` reads 0. In the following cycle `iss_valid` is 1. The issued piece has `iss_line` = address >> log2(LINE_BYTES), `iss_off` = address & (LINE_BYTES-1), `iss_len` = min(length, LINE_BYTES - offset), the request's direction, and `iss_id` = the `req_id` shown at acceptance, which is the lowest free slot.
- R3: When MAX_OUT requests are outstanding, `req_status` reads 1 (full) and nothing is issued.
- R4: If any line from the request's first line to its last line lies within the remaining line span of a pending request, `req_status` reads 2 (aliased) and nothing is issued. This check applies only when the table is not full.
- R5: A response may need the issue port for its next piece in the same cycle as a new request. In that case the request gets `req_status` 3 (retry) and is not taken, and the response's piece is issued.
- R6: A response matches a pending request by line address. If that request still has bytes left to issue, the next cycle issues a piece with line + 1, offset 0, length min(remaining, LINE_BYTES) and the same `iss_id`.
- R7: A response that brings a request's completed bytes to its length pulses `done_valid` in the next cycle, with `done_id` and `done_write`. No further piece is issued, and the slot becomes free for the next accepted request.
- R8: For a read, every response pulses `rd_valid` in the next cycle. `rd_pos` is the count of bytes completed before this response and `rd_len` is the byte count of the piece. `rd_data` holds those bytes of the line, starting at the start offset for the first piece and at byte 0 for later pieces. The bytes sit from byte 0 upward, and bytes above `rd_len` are zero.
- R9: A response to a write request never raises `rd_valid`.
- R10: A response whose line matches no pending piece pulses `rsp_err` in the next cycle. It produces no issue, no read beat and no completion.
- R11: `busy` is 1 exactly while at least one request is outstanding.
- R12: Requests that are outstanding together complete in the order their responses arrive, independent of the order in which they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | New request offered this cycle |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Byte count, nonzero |
| req_write | input | 1 | 1 = write, 0 = read |
| req_status | output | 2 | 0 taken, 1 full, 2 aliased, 3 retry |
| req_id | output | ID_W | Slot given to the request if taken |
| iss_valid | output | 1 | Piece issued downstream |
| iss_line | output | LINE_W | Line address of the piece |
| iss_off | output | OFF_W | Byte offset within the line |
| iss_len | output | CLEN_W | Bytes in the piece |
| iss_write | output | 1 | Direction of the piece |
| iss_id | output | ID_W | Slot of the owning request |
| rsp_valid | input | 1 | Data or acknowledge response |
| rsp_line | input | LINE_W | Line address the response answers |
| rsp_data | input | DATA_W | Line data (reads) |
| rd_valid | output | 1 | Read beat for the requester |
| rd_id | output | ID_W | Slot of the read |
| rd_pos | output | LEN_W | Destination byte position in the transfer |
| rd_len | output | CLEN_W | Valid bytes in the beat |
| rd_data | output | DATA_W | Beat data aligned to byte 0 |
| done_valid | output | 1 | Request completed |
| done_id | output | ID_W | Slot that completed |
| done_write | output | 1 | Direction of the completed request |
| rsp_err | output | 1 | Response matched no pending piece |
| busy | output | 1 | Any request outstanding |

## Verification
The bench builds the tracker with 8-byte lines, 16-bit addresses, 8-bit lengths and MAX_OUT = 3. With a three-slot table the full refusal is reached after three requests, and slot reuse can be seen on a freed middle slot. The short lines let a 10-byte read from offset 3 and a 16-byte transfer cross a line boundary. That exercises the first-piece offset, the line + 1 sequencing, the byte positions of the read beats and the retry collision between a follow-on piece and a new request.

// File: rtl/dmt_pkg.sv
// Shared encodings of the DMA request tracker.
// Assumes: nothing beyond standard SystemVerilog.
package dmt_pkg;
    typedef enum logic [1:0] {
        REQ_TAKEN = 2'd0,
        REQ_FULL  = 2'd1,
        REQ_ALIAS = 2'd2,
        REQ_RETRY = 2'd3
    } req_status_e;
endpackage

// File: rtl/dmt_chunker.sv
// Piece sizer: the smaller of the bytes left in the transfer and the
// bytes left in the current line.
// Assumes: room never exceeds one line, so the result fits CLEN_W.
module dmt_chunker #(
    parameter int LEN_W  = 16,
    parameter int CLEN_W = 7
) (
    input  logic [LEN_W-1:0]  remain,
    input  logic [CLEN_W-1:0] room,
    output logic [CLEN_W-1:0] clen
);
    localparam int W = (LEN_W > CLEN_W) ? LEN_W : CLEN_W;

    logic [W-1:0] remain_w;
    logic [W-1:0] room_w;

    // Widen both operands and pick the minimum.
    always_comb begin
        remain_w = W'(remain);
        room_w   = W'(room);
        clen     = (remain_w < room_w) ? CLEN_W'(remain_w) : room;
    end
endmodule

// File: rtl/dmt_extract.sv
// Read beat former: shifts the wanted bytes of a line down to byte 0 and
// zeroes every byte at or above the byte count.
// Assumes: off + nbytes <= LINE_BYTES.
module dmt_extract #(
    parameter int LINE_BYTES = 64,
    parameter int OFF_W      = 6,
    parameter int CLEN_W     = 7
) (
    input  logic [LINE_BYTES*8-1:0] line_data,
    input  logic [OFF_W-1:0]        off,
    input  logic [CLEN_W-1:0]       nbytes,
    output logic [LINE_BYTES*8-1:0] data_o
);
    logic [LINE_BYTES*8-1:0] shifted;

    // Move the first wanted byte to position 0.
    always_comb shifted = line_data >> {off, 3'b000};

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
        // Keep a byte only if it lies inside the piece.
        assign data_o[b*8 +: 8] = (CLEN_W'(b) < nbytes) ? shifted[b*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/dmt_table.sv
// Fully associative request table. Each slot holds the line of its
// in-flight piece, the last line of the transfer, the start offset, the
// length, the bytes issued and completed, and the direction. There are two
// parallel search ports: an exact line match for responses and a span
// overlap test for new requests. The table also finds the lowest free slot.
// Assumes: alloc, update and free never target the same slot in a cycle.
module dmt_table #(
    parameter int N      = 64,
    parameter int LINE_W = 26,
    parameter int OFF_W  = 6,
    parameter int LEN_W  = 16,
    parameter int ID_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [ID_W-1:0]   alloc_idx,
    input  logic [LINE_W-1:0] alloc_line,
    input  logic [LINE_W-1:0] alloc_last,
    input  logic [OFF_W-1:0]  alloc_off,
    input  logic [LEN_W-1:0]  alloc_len,
    input  logic [LEN_W-1:0]  alloc_issued,
    input  logic              alloc_write,
    input  logic              upd_en,
    input  logic [ID_W-1:0]   upd_idx,
    input  logic [LINE_W-1:0] upd_line,
    input  logic [LEN_W-1:0]  upd_issued,
    input  logic [LEN_W-1:0]  upd_completed,
    input  logic              free_en,
    input  logic [ID_W-1:0]   free_idx,
    input  logic [LINE_W-1:0] probe_first,
    input  logic [LINE_W-1:0] probe_last,
    output logic              probe_overlap,
    input  logic [LINE_W-1:0] look_line,
    output logic              look_hit,
    output logic [ID_W-1:0]   look_idx,
    output logic [OFF_W-1:0]  look_off,
    output logic [LEN_W-1:0]  look_len,
    output logic [LEN_W-1:0]  look_issued,
    output logic [LEN_W-1:0]  look_completed,
    output logic              look_write,
    output logic              vacant_any,
    output logic [ID_W-1:0]   vacant_idx
);
    logic [N-1:0]      ent_valid;
    logic [LINE_W-1:0] ent_line [N];
    logic [LINE_W-1:0] ent_last [N];
    logic [OFF_W-1:0]  ent_off  [N];
    logic [LEN_W-1:0]  ent_len  [N];
    logic [LEN_W-1:0]  ent_iss  [N];
    logic [LEN_W-1:0]  ent_cmp  [N];
    logic              ent_wr   [N];
    logic [N-1:0]      hit_vec;
    logic [N-1:0]      ovl_vec;

    for (genvar g = 0; g < N; g++) begin : g_slot
        // Slot occupancy: set on allocate, cleared on free.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_valid[g] <= 1'b0;
            end else if (alloc_en && alloc_idx == ID_W'(g)) begin
                ent_valid[g] <= 1'b1;
            end else if (free_en && free_idx == ID_W'(g)) begin
                ent_valid[g] <= 1'b0;
            end
        end

        // Slot payload: loaded on allocate, advanced on each non-final response.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_line[g] <= '0;
                ent_last[g] <= '0;
                ent_off[g]  <= '0;
                ent_len[g]  <= '0;
                ent_iss[g]  <= '0;
                ent_cmp[g]  <= '0;
                ent_wr[g]   <= 1'b0;
            end else if (alloc_en && alloc_idx == ID_W'(g)) begin
                ent_line[g] <= alloc_line;
                ent_last[g] <= alloc_last;
                ent_off[g]  <= alloc_off;
                ent_len[g]  <= alloc_len;
                ent_iss[g]  <= alloc_issued;
                ent_cmp[g]  <= '0;
                ent_wr[g]   <= alloc_write;
            end else if (upd_en && upd_idx == ID_W'(g)) begin
                ent_line[g] <= upd_line;
                ent_iss[g]  <= upd_issued;
                ent_cmp[g]  <= upd_completed;
            end
        end

        // Exact match of the in-flight line against the response tag.
        assign hit_vec[g] = ent_valid[g] && (ent_line[g] == look_line);
        // Overlap of the remaining span with the new request's span.
        assign ovl_vec[g] = ent_valid[g] && (probe_first <= ent_last[g])
                                         && (ent_line[g] <= probe_last);
    end

    // Any overlap refuses the new request.
    always_comb probe_overlap = |ovl_vec;

    // Lowest-index encoders for the response hit and for the free slot.
    always_comb begin
        look_hit   = |hit_vec;
        vacant_any = ~&ent_valid;
        look_idx   = '0;
        vacant_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) look_idx = ID_W'(i);
            if (!ent_valid[i]) vacant_idx = ID_W'(i);
        end
    end

    // Read out the payload of the matched slot.
    always_comb begin
        look_off       = ent_off[look_idx];
        look_len       = ent_len[look_idx];
        look_issued    = ent_iss[look_idx];
        look_completed = ent_cmp[look_idx];
        look_write     = ent_wr[look_idx];
    end
endmodule

// File: rtl/dmt_tracker.sv
// Multi-outstanding DMA request tracker top. It accepts or refuses requests,
// splits them into line pieces, issues one piece per request at a time,
// matches responses by line address, forms read beats and reports completion.
// Assumes: req_len is nonzero and the transfer does not wrap the address
// space; the downstream side accepts every issued piece.
module dmt_tracker #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int LINE_BYTES = 64,
    parameter int MAX_OUT    = 64,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int LINE_W = ADDR_W - OFF_W,
    localparam int CLEN_W = OFF_W + 1,
    localparam int DATA_W = LINE_BYTES * 8,
    localparam int ID_W   = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1,
    localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_write,
    output logic [1:0]        req_status,
    output logic [ID_W-1:0]   req_id,
    output logic              iss_valid,
    output logic [LINE_W-1:0] iss_line,
    output logic [OFF_W-1:0]  iss_off,
    output logic [CLEN_W-1:0] iss_len,
    output logic              iss_write,
    output logic [ID_W-1:0]   iss_id,
    input  logic              rsp_valid,
    input  logic [LINE_W-1:0] rsp_line,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              rd_valid,
    output logic [ID_W-1:0]   rd_id,
    output logic [LEN_W-1:0]  rd_pos,
    output logic [CLEN_W-1:0] rd_len,
    output logic [DATA_W-1:0] rd_data,
    output logic              done_valid,
    output logic [ID_W-1:0]   done_id,
    output logic              done_write,
    output logic              rsp_err,
    output logic              busy
);
    import dmt_pkg::*;

    logic [CNT_W-1:0]  outstanding;
    logic [LINE_W-1:0] req_first_line;
    logic [LINE_W-1:0] req_last_line;
    logic [OFF_W-1:0]  req_off;
    logic [ADDR_W-1:0] req_end_addr;
    logic [CLEN_W-1:0] req_room;
    logic [CLEN_W-1:0] first_clen;
    logic              span_overlap;
    logic              vacant_any;
    logic [ID_W-1:0]   vacant_idx;

    logic              rsp_hit;
    logic [ID_W-1:0]   rsp_idx;
    logic [OFF_W-1:0]  e_off;
    logic [LEN_W-1:0]  e_len;
    logic [LEN_W-1:0]  e_issued;
    logic [LEN_W-1:0]  e_completed;
    logic              e_write;
    logic              rsp_take;
    logic              rsp_last;
    logic              port_claimed;
    logic              retire;
    logic [LEN_W-1:0]  next_remain;
    logic [CLEN_W-1:0] next_clen;
    logic [LEN_W-1:0]  piece_bytes;
    logic [OFF_W-1:0]  src_off;
    logic [DATA_W-1:0] beat_data;

    logic              tbl_full;
    logic              accept;

    // Split the request address into line and offset, and find its last line.
    always_comb begin
        req_first_line = req_addr[ADDR_W-1:OFF_W];
        req_off        = req_addr[OFF_W-1:0];
        req_end_addr   = req_addr + ADDR_W'(req_len) - ADDR_W'(1);
        req_last_line  = req_end_addr[ADDR_W-1:OFF_W];
        req_room       = CLEN_W'(LINE_BYTES) - CLEN_W'(req_off);
    end

    dmt_chunker #(.LEN_W(LEN_W), .CLEN_W(CLEN_W)) u_first_chunk (
        .remain (req_len),
        .room   (req_room),
        .clen   (first_clen)
    );

    // Response decode: hit, last piece and the size of the follow-on piece.
    always_comb begin
        rsp_take     = rsp_valid && rsp_hit;
        rsp_last     = (e_issued == e_len);
        port_claimed = rsp_take && !rsp_last;
        retire       = rsp_take && rsp_last;
        next_remain  = e_len - e_issued;
        piece_bytes  = e_issued - e_completed;
        src_off      = (e_completed == '0) ? e_off : '0;
    end

    dmt_chunker #(.LEN_W(LEN_W), .CLEN_W(CLEN_W)) u_next_chunk (
        .remain (next_remain),
        .room   (CLEN_W'(LINE_BYTES)),
        .clen   (next_clen)
    );

    dmt_extract #(.LINE_BYTES(LINE_BYTES), .OFF_W(OFF_W), .CLEN_W(CLEN_W)) u_extract (
        .line_data (rsp_data),
        .off       (src_off),
        .nbytes    (CLEN_W'(piece_bytes)),
        .data_o    (beat_data)
    );

    // Admission: full first, then aliased, then a port collision.
    always_comb begin
        tbl_full = (outstanding == CNT_W'(MAX_OUT)) || !vacant_any;
        accept   = 1'b0;
        if (tbl_full) begin
            req_status = REQ_FULL;
        end else if (span_overlap) begin
            req_status = REQ_ALIAS;
        end else if (port_claimed) begin
            req_status = REQ_RETRY;
        end else begin
            req_status = REQ_TAKEN;
            accept     = req_valid;
        end
        req_id = vacant_idx;
    end

    dmt_table #(
        .N(MAX_OUT), .LINE_W(LINE_W), .OFF_W(OFF_W), .LEN_W(LEN_W), .ID_W(ID_W)
    ) u_table (
        .clk            (clk),
        .rst_n          (rst_n),
        .alloc_en       (accept),
        .alloc_idx      (vacant_idx),
        .alloc_line     (req_first_line),
        .alloc_last     (req_last_line),
        .alloc_off      (req_off),
        .alloc_len      (req_len),
        .alloc_issued   (LEN_W'(first_clen)),
        .alloc_write    (req_write),
        .upd_en         (port_claimed),
        .upd_idx        (rsp_idx),
        .upd_line       (rsp_line + LINE_W'(1)),
        .upd_issued     (e_issued + LEN_W'(next_clen)),
        .upd_completed  (e_issued),
        .free_en        (retire),
        .free_idx       (rsp_idx),
        .probe_first    (req_first_line),
        .probe_last     (req_last_line),
        .probe_overlap  (span_overlap),
        .look_line      (rsp_line),
        .look_hit       (rsp_hit),
        .look_idx       (rsp_idx),
        .look_off       (e_off),
        .look_len       (e_len),
        .look_issued    (e_issued),
        .look_completed (e_completed),
        .look_write     (e_write),
        .vacant_any     (vacant_any),
        .vacant_idx     (vacant_idx)
    );

    // Outstanding counter: up on accept, down on retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= '0;
        end else begin
            outstanding <= outstanding + CNT_W'(accept) - CNT_W'(retire);
        end
    end

    always_comb busy = (outstanding != '0);

    // Issue port: the follow-on piece of a response wins over a new request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_valid <= 1'b0;
            iss_line  <= '0;
            iss_off   <= '0;
            iss_len   <= '0;
            iss_write <= 1'b0;
            iss_id    <= '0;
        end else begin
            iss_valid <= accept || port_claimed;
            if (port_claimed) begin
                iss_line  <= rsp_line + LINE_W'(1);
                iss_off   <= '0;
                iss_len   <= next_clen;
                iss_write <= e_write;
                iss_id    <= rsp_idx;
            end else if (accept) begin
                iss_line  <= req_first_line;
                iss_off   <= req_off;
                iss_len   <= first_clen;
                iss_write <= req_write;
                iss_id    <= vacant_idx;
            end
        end
    end

    // Read beat toward the requester, one per response to a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_id    <= '0;
            rd_pos   <= '0;
            rd_len   <= '0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rsp_take && !e_write;
            if (rsp_take && !e_write) begin
                rd_id   <= rsp_idx;
                rd_pos  <= e_completed;
                rd_len  <= CLEN_W'(piece_bytes);
                rd_data <= beat_data;
            end
        end
    end

    // Completion and unmatched-response reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_valid <= 1'b0;
            done_id    <= '0;
            done_write <= 1'b0;
            rsp_err    <= 1'b0;
        end else begin
            done_valid <= retire;
            rsp_err    <= rsp_valid && !rsp_hit;
            if (retire) begin
                done_id    <= rsp_idx;
                done_write <= e_write;
            end
        end
    end
endmodule

// File: rtl/dmt_tracker_chk.sv
// Property checker for the DMA request tracker, bound to every instance.
// Assumes: the same parameter values as the bound top.
module dmt_tracker_chk #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int LINE_BYTES = 64,
    parameter int MAX_OUT    = 64,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int CLEN_W = OFF_W + 1,
    localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_status,
    input logic              iss_valid,
    input logic [OFF_W-1:0]  iss_off,
    input logic              rd_valid,
    input logic [CLEN_W-1:0] rd_len,
    input logic              done_valid,
    input logic              rsp_err,
    input logic              busy,
    input logic [CNT_W-1:0]  outstanding
);
    p_accept_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_status == 2'd0 |=> iss_valid && iss_off == $past(req_addr[OFF_W-1:0]));

    p_full_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding == CNT_W'(MAX_OUT) |-> req_status != 2'd0);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding <= CNT_W'(MAX_OUT));

    p_retry_piece_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_status == 2'd3 |=> iss_valid && iss_off == '0);

    p_done_had_work_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> $past(outstanding) != '0);

    p_beat_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_len != '0 && rd_len <= CLEN_W'(LINE_BYTES));

    p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> !done_valid && !rd_valid);

    p_issue_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> busy);
endmodule

bind dmt_tracker dmt_tracker_chk #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES), .MAX_OUT(MAX_OUT)
) u_chk (.*);

// File: tb/tb_dmt_tracker.sv
// Directed bench for the DMA request tracker: one task per scenario.
module tb_dmt_tracker;
    localparam int ADDR_W = 16;
    localparam int LEN_W  = 8;
    localparam int LB     = 8;
    localparam int MAXO   = 3;
    localparam int OFF_W  = 3;
    localparam int LINE_W = 13;
    localparam int CLEN_W = 4;
    localparam int DATA_W = 64;
    localparam int ID_W   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              req_write = 1'b0;
    logic [1:0]        req_status;
    logic [ID_W-1:0]   req_id;
    logic              iss_valid;
    logic [LINE_W-1:0] iss_line;
    logic [OFF_W-1:0]  iss_off;
    logic [CLEN_W-1:0] iss_len;
    logic              iss_write;
    logic [ID_W-1:0]   iss_id;
    logic              rsp_valid = 1'b0;
    logic [LINE_W-1:0] rsp_line = '0;
    logic [DATA_W-1:0] rsp_data = '0;
    logic              rd_valid;
    logic [ID_W-1:0]   rd_id;
    logic [LEN_W-1:0]  rd_pos;
    logic [CLEN_W-1:0] rd_len;
    logic [DATA_W-1:0] rd_data;
    logic              done_valid;
    logic [ID_W-1:0]   done_id;
    logic              done_write;
    logic              rsp_err;
    logic              busy;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;
    logic [1:0]      st;
    logic [ID_W-1:0] sid;

    always #5 clk = ~clk;

    dmt_tracker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LB), .MAX_OUT(MAXO)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .req_write(req_write), .req_status(req_status), .req_id(req_id),
        .iss_valid(iss_valid), .iss_line(iss_line), .iss_off(iss_off), .iss_len(iss_len),
        .iss_write(iss_write), .iss_id(iss_id), .rsp_valid(rsp_valid), .rsp_line(rsp_line),
        .rsp_data(rsp_data), .rd_valid(rd_valid), .rd_id(rd_id), .rd_pos(rd_pos),
        .rd_len(rd_len), .rd_data(rd_data), .done_valid(done_valid), .done_id(done_id),
        .done_write(done_write), .rsp_err(rsp_err), .busy(busy)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mkline(input logic [7:0] base);
        logic [63:0] r;
        for (int i = 0; i < LB; i++) r[i*8 +: 8] = base + 8'(i);
        return r;
    endfunction

    function automatic logic [63:0] pick(input logic [63:0] d, input int off, input int n);
        logic [63:0] r = '0;
        for (int b = 0; b < n; b++) r[b*8 +: 8] = d[(off+b)*8 +: 8];
        return r;
    endfunction

    // All stimulus tasks start and end 1 ns after a rising edge.
    task automatic send_req(input logic [15:0] a, input logic [7:0] l, input logic w);
        req_valid = 1'b1; req_addr = a; req_len = l; req_write = w;
        #3 st = req_status; sid = req_id;
        @(posedge clk); #1 req_valid = 1'b0;
    endtask

    task automatic send_rsp(input logic [12:0] line, input logic [63:0] d);
        rsp_valid = 1'b1; rsp_line = line; rsp_data = d;
        @(posedge clk); #1 rsp_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 busy", busy, 0);
        chk("R1 iss_valid", iss_valid, 0);
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 done_valid", done_valid, 0);
        chk("R1 rsp_err", rsp_err, 0);
    endtask

    task automatic t_read_two_lines;
        logic [63:0] d0 = mkline(8'h10);
        logic [63:0] d1 = mkline(8'h20);
        send_req(16'h0013, 8'd10, 1'b0);
        chk("R2 status", st, 0);
        chk("R2 id", sid, 0);
        chk("R2 iss_valid", iss_valid, 1);
        chk("R2 iss_line", iss_line, 2);
        chk("R2 iss_off", iss_off, 3);
        chk("R2 iss_len", iss_len, 5);
        chk("R2 iss_write", iss_write, 0);
        chk("R11 busy on", busy, 1);
        send_rsp(13'd2, d0);
        chk("R8 rd_valid first", rd_valid, 1);
        chk("R8 rd_pos first", rd_pos, 0);
        chk("R8 rd_len first", rd_len, 5);
        chk("R8 rd_data first", rd_data, pick(d0, 3, 5));
        chk("R6 iss_valid", iss_valid, 1);
        chk("R6 iss_line", iss_line, 3);
        chk("R6 iss_off", iss_off, 0);
        chk("R6 iss_len", iss_len, 5);
        chk("R6 iss_id", iss_id, 0);
        chk("R6 not done", done_valid, 0);
        send_rsp(13'd3, d1);
        chk("R8 rd_pos second", rd_pos, 5);
        chk("R8 rd_len second", rd_len, 5);
        chk("R8 rd_data second", rd_data, pick(d1, 0, 5));
        chk("R7 done_valid", done_valid, 1);
        chk("R7 done_id", done_id, 0);
        chk("R7 done_write", done_write, 0);
        chk("R7 no issue after last", iss_valid, 0);
        chk("R11 busy off", busy, 0);
    endtask

    task automatic t_write_ack;
        send_req(16'h0040, 8'd8, 1'b1);
        chk("R2 write status", st, 0);
        chk("R2 write iss_len", iss_len, 8);
        chk("R2 write iss_write", iss_write, 1);
        send_rsp(13'd8, 64'h0);
        chk("R9 no rd beat", rd_valid, 0);
        chk("R7 write done", done_valid, 1);
        chk("R7 write done_write", done_write, 1);
    endtask

    task automatic t_full_alias;
        send_req(16'd128, 8'd1, 1'b0); chk("R12 take a", st, 0);
        send_req(16'd144, 8'd1, 1'b0); chk("R12 take b", st, 0);
        send_req(16'd160, 8'd1, 1'b0); chk("R12 take c", st, 0);
        send_req(16'd176, 8'd1, 1'b0);
        chk("R3 full status", st, 1);
        chk("R3 full no issue", iss_valid, 0);
        send_rsp(13'd18, mkline(8'h40));
        chk("R12 out of order done", done_valid, 1);
        chk("R12 out of order id", done_id, 1);
        send_req(16'd176, 8'd1, 1'b0);
        chk("R7 reuse status", st, 0);
        chk("R7 reuse slot", iss_id, 1);
        send_rsp(13'd20, mkline(8'h50));
        chk("R12 done c id", done_id, 2);
        send_req(16'd128, 8'd1, 1'b0);
        chk("R4 alias same line", st, 2);
        chk("R4 alias no issue", iss_valid, 0);
        send_req(16'd124, 8'd12, 1'b0);
        chk("R4 alias by span", st, 2);
        send_rsp(13'd16, mkline(8'h60));
        chk("R12 done a id", done_id, 0);
        send_rsp(13'd22, mkline(8'h70));
        chk("R12 done d id", done_id, 1);
        chk("R11 idle again", busy, 0);
    endtask

    task automatic t_unknown;
        send_rsp(13'h50, 64'h0);
        chk("R10 rsp_err", rsp_err, 1);
        chk("R10 no done", done_valid, 0);
        chk("R10 no beat", rd_valid, 0);
        chk("R10 no issue", iss_valid, 0);
    endtask

    task automatic t_retry;
        send_req(16'd240, 8'd16, 1'b1);
        chk("R2 long status", st, 0);
        rsp_valid = 1'b1; rsp_line = 13'd30; rsp_data = '0;
        req_valid = 1'b1; req_addr = 16'd320; req_len = 8'd4; req_write = 1'b0;
        #3 st = req_status;
        @(posedge clk); #1 rsp_valid = 1'b0; req_valid = 1'b0;
        chk("R5 retry status", st, 3);
        chk("R5 piece issued", iss_line, 31);
        chk("R5 piece len", iss_len, 8);
        chk("R5 piece id", iss_id, 0);
        send_req(16'd320, 8'd4, 1'b0);
        chk("R5 retaken", st, 0);
        chk("R5 retaken line", iss_line, 40);
        send_rsp(13'd31, '0);
        chk("R7 long done id", done_id, 0);
        send_rsp(13'd40, mkline(8'h80));
        chk("R8 short beat", rd_data, pick(mkline(8'h80), 0, 4));
        chk("R7 short done id", done_id, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset;
        t_read_two_lines;
        t_write_ack;
        t_full_alias;
        t_unknown;
        t_retry;
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule